// File: doc/BRIEF.md
# System Control Register Bank

A bank of 32-bit configuration and status words for the global control area of a chip. Software reaches it through a plain word-wide bus: a word address, a write strobe, a read strobe, write data and registered read data. Every word in the decoded range is backed by a flop register. Each register follows one of four write rules:

- plain storage
- ignore all writes
- clear the bits written as one
- set the bits written as one

When reset is asserted, the bank loads a fixed table of start-up values. Two words are the exception. The board strap word and the module-disable word load from input ports, which are sampled while reset is held.

Software uses the bank to read the chip identity and the straps, to latch lock bits and disabled-module bits that cannot be undone, and to clear reset-cause flags. It also uses a scratch word as a mailbox: a secondary processor polls that word during multi-core start-up. The bus address carries byte-address bits 11 down to 2, so every access is an aligned 32-bit word inside a 4 KiB window. Word index k sits at byte offset 4*k. Words 0 through 81 (byte offsets 0x000 to 0x144) are decoded. Any higher word is outside the bank.

Top module: `scb_ctrl_regs`

## Requirements
- R1: While reset is low, every decoded word loads its start-up value. The nonzero values are:
  - 0x13C = 0x00000008
  - 0x000 = 0x04A92750
  - 0x098 = 0x5A00F3CF
  - 0x140 and 0x144 = 0x034730E4
  - 0x014 = 0x0000FFFF
  - 0x06C = 0x80000000
  - 0x038 = 0x00000003
  - 0x03C = 0x0000035E
  - 0x050 = 0x0000004E
  - 0x078 = 0x000000C0
  - 0x09C = 0x00001002

  Every other word, including all gap words, resets to zero.
- R2: During reset, the word at 0x004 takes the value on `strap_word` and the word at 0x07C takes the value on `variant_word`. After reset is released, later changes on those inputs have no effect.
- R3: The words at 0x000, 0x004 and 0x040 are read-only. A write to any of them leaves its value unchanged.
- R4: The words at 0x06C and 0x0D4 are write-one-to-clear. A write makes the new value equal to the old value AND NOT the write data, so bits written as zero keep their value.
- R5: The words at 0x070 and 0x07C are write-one-to-set. A write makes the new value equal to the old value OR the write data, so no write can clear a bit once it is set.
- R6: Every other decoded word is plain storage and reads back the last value written. This covers gap words between named registers and the scratch word at 0x13C.
- R7: A read of any word at byte offset 0x148 or above returns zero. A write there changes no register.
- R8: Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high. If a read and a write to the same word happen in one cycle, the read returns the value from before the write.
- R9: `bus_rdata` holds its last value in every cycle without a read, and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 10 | Word address, byte-address bits [11:2] |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| strap_word | input | 32 | Board strap value, loaded into 0x004 during reset |
| variant_word | input | 32 | Chip-variant disable mask, loaded into 0x07C during reset |

## Verification
A write takes effect at the rising edge on which the strobe is seen. A read issued in the same or any later cycle shows that edge's update one edge later. The bench drives every strobe after a falling edge and removes it after the next falling edge, so each access spans exactly one rising edge. It samples `bus_rdata` at the falling edge that follows the capturing rising edge, which lands between the register update and the next edge. In the same-cycle case, a combined read-and-write is sampled at that falling edge and must show the old word. A separate read issued afterwards must show the new word. Hold behaviour is checked by sampling `bus_rdata` across idle and write-only cycles following a read.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, access-rule type and per-word tables for the
// control register bank. Assumes 32-bit words and a 4 KiB byte window.
package scb_pkg;

    localparam int SCB_DW      = 32;   // word width in bits
    localparam int SCB_WORDS   = 82;   // decoded words, offsets 0x000..0x144
    localparam int SCB_ADDR_W  = 12;   // byte address width of the window
    localparam int IDX_STRAP   = 1;    // word loaded from board straps (0x004)
    localparam int IDX_VARIANT = 31;   // word loaded from variant mask (0x07C)

    typedef enum logic [1:0] {
        ACC_RW  = 2'd0,
        ACC_RO  = 2'd1,
        ACC_W1C = 2'd2,
        ACC_W1S = 2'd3
    } acc_kind_e;

    // Write rule of each word index
    function automatic acc_kind_e kind_of(input int unsigned idx);
        case (idx)
            0, 1, 16: kind_of = ACC_RO;
            27, 53:   kind_of = ACC_W1C;
            28, 31:   kind_of = ACC_W1S;
            default:  kind_of = ACC_RW;
        endcase
    endfunction

    // Fixed start-up value of each word index (strap words handled in top)
    function automatic logic [SCB_DW-1:0] fixed_init(input int unsigned idx);
        case (idx)
            0:       fixed_init = 32'h04A9_2750;
            5:       fixed_init = 32'h0000_FFFF;
            14:      fixed_init = 32'h0000_0003;
            15:      fixed_init = 32'h0000_035E;
            20:      fixed_init = 32'h0000_004E;
            27:      fixed_init = 32'h8000_0000;
            30:      fixed_init = 32'h0000_00C0;
            38:      fixed_init = 32'h5A00_F3CF;
            39:      fixed_init = 32'h0000_1002;
            79:      fixed_init = 32'h0000_0008;
            80, 81:  fixed_init = 32'h0347_30E4;
            default: fixed_init = '0;
        endcase
    endfunction

endpackage

// File: rtl/scb_addr_dec.sv
`timescale 1ns/1ps
// Module: scb_addr_dec
// Turns a word address into an in-range flag and a one-hot write select.
// Assumes the address is already word aligned; words at or above WORDS
// are outside the bank and select nothing.
module scb_addr_dec #(
    parameter int WORDS = 82,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] word_idx,
    input  logic             wr,
    output logic             in_range,
    output logic [WORDS-1:0] wr_sel
);

    // Range check against the decoded word count
    always_comb in_range = (int'(word_idx) < WORDS);

    // One select line per word, live only for an in-range write
    for (genvar i = 0; i < WORDS; i++) begin : g_sel
        assign wr_sel[i] = wr && in_range && (int'(word_idx) == i);
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R6
    AST_OOR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(word_idx) >= WORDS) |-> (wr_sel == '0)); // R7

endmodule

// File: rtl/scb_word.sv
`timescale 1ns/1ps
// Module: scb_word
// One 32-bit register applying its write rule: plain, read-only,
// write-one-to-clear or write-one-to-set. Assumes init_val is stable
// while reset is low; reset is synchronous, active low.
module scb_word
    import scb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_kind_e     kind,
    input  logic [DW-1:0] init_val,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic [DW-1:0] nxt;
    logic          live_q;

    // Next value under this word's write rule
    always_comb begin
        case (kind)
            ACC_RO:  nxt = q;
            ACC_W1C: nxt = q & ~wdata;
            ACC_W1S: nxt = q | wdata;
            default: nxt = wdata;
        endcase
    end

    // Storage: load start-up value in reset, else apply writes
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= init_val;
        else if (wr_en) q <= nxt;
    end

    // Marks cycles whose previous cycle was already out of reset
    always_ff @(posedge clk) live_q <= rst_n;

    AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && kind == ACC_RO) |-> $stable(q)); // R3
    AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && kind == ACC_W1C) |-> ((q & ~$past(q)) == '0)); // R4
    AST_W1S_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && kind == ACC_W1S) |-> ((q & $past(q)) == $past(q))); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(wr_en)) |-> $stable(q)); // R7

endmodule

// File: rtl/scb_rd_mux.sv
`timescale 1ns/1ps
// Module: scb_rd_mux
// Registered read path: picks the addressed word on a read strobe and
// holds the result otherwise. Out-of-range reads return zero. Assumes
// sel is meaningful only while in_range is high.
module scb_rd_mux #(
    parameter int DW    = 32,
    parameter int WORDS = 82,
    parameter int SEL_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORDS-1:0][DW-1:0]  words,
    input  logic [SEL_W-1:0]          sel,
    input  logic                      in_range,
    input  logic                      rd,
    output logic [DW-1:0]             rdata
);

    // Capture addressed word (or zero) on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= in_range ? words[sel] : '0;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R9

endmodule

// File: rtl/scb_ctrl_regs.sv
`timescale 1ns/1ps
// Module: scb_ctrl_regs
// Top of the system control register bank. Decodes word addresses,
// instantiates one register per decoded word with its write rule and
// start-up value, and returns registered read data. Assumes aligned
// word accesses only; reset is synchronous, active low.
module scb_ctrl_regs
    import scb_pkg::*;
#(
    parameter int DATA_W = SCB_DW,
    parameter int WORDS  = SCB_WORDS,
    parameter int ADDR_W = SCB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] strap_word,
    input  logic [DATA_W-1:0] variant_word
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(WORDS);

    logic [IDX_W-1:0]             word_idx;
    logic                         in_range;
    logic [WORDS-1:0]             wr_sel;
    logic [WORDS-1:0][DATA_W-1:0] words;

    // Word index straight from the word address
    always_comb word_idx = bus_addr;

    scb_addr_dec #(.WORDS(WORDS), .IDX_W(IDX_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_idx (word_idx),
        .wr       (bus_wr),
        .in_range (in_range),
        .wr_sel   (wr_sel)
    );

    // One register per decoded word, rule and start-up value per index
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        acc_kind_e         kind_i;
        logic [DATA_W-1:0] init_i;

        always_comb kind_i = kind_of(i);

        if (i == IDX_STRAP) begin : g_strap
            always_comb init_i = strap_word;
        end else if (i == IDX_VARIANT) begin : g_variant
            always_comb init_i = variant_word;
        end else begin : g_fixed
            always_comb init_i = DATA_W'(fixed_init(i));
        end

        scb_word #(.DW(DATA_W)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .kind     (kind_i),
            .init_val (init_i),
            .wr_en    (wr_sel[i]),
            .wdata    (bus_wdata),
            .q        (words[i])
        );
    end

    scb_rd_mux #(.DW(DATA_W), .WORDS(WORDS), .SEL_W(SEL_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .words    (words),
        .sel      (word_idx[SEL_W-1:0]),
        .in_range (in_range),
        .rd       (bus_rd),
        .rdata    (bus_rdata)
    );

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> (bus_rdata == '0)); // R7
    AST_STRAP_LOAD: assert property (@(posedge clk)
        !rst_n |=> (words[IDX_STRAP] == $past(strap_word))); // R2

endmodule

// File: tb/scb_ctrl_regs_tb.sv
`timescale 1ns/1ps
// Directed bench for scb_ctrl_regs: one task per scenario.
module scb_ctrl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:2] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] strap_word = 32'h1234_5678;
    logic [31:0] variant_word = 32'h0000_0300;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    scb_ctrl_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .strap_word   (strap_word),
        .variant_word (variant_word)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic apply_reset(input logic [31:0] s, input logic [31:0] v);
        @(negedge clk);
        rst_n = 1'b0; strap_word = s; variant_word = v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_word = ~s; variant_word = ~v;   // later changes must not matter
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:2]; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:2]; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_word(input string req, input logic [11:0] a,
                               input logic [31:0] exp);
        logic [31:0] d;
        rd_word(a, d);
        check(req, d, exp);
    endtask

    // R1, R2, R9: start-up values after the first reset
    task automatic t_reset_values();
        check("R9 rdata after reset", bus_rdata, 32'h0);
        expect_word("R1 0x000", 12'h000, 32'h04A9_2750);
        expect_word("R1 0x014", 12'h014, 32'h0000_FFFF);
        expect_word("R1 0x038", 12'h038, 32'h0000_0003);
        expect_word("R1 0x03C", 12'h03C, 32'h0000_035E);
        expect_word("R1 0x050", 12'h050, 32'h0000_004E);
        expect_word("R1 0x06C", 12'h06C, 32'h8000_0000);
        expect_word("R1 0x078", 12'h078, 32'h0000_00C0);
        expect_word("R1 0x098", 12'h098, 32'h5A00_F3CF);
        expect_word("R1 0x09C", 12'h09C, 32'h0000_1002);
        expect_word("R1 0x13C", 12'h13C, 32'h0000_0008);
        expect_word("R1 0x140", 12'h140, 32'h0347_30E4);
        expect_word("R1 0x144", 12'h144, 32'h0347_30E4);
        expect_word("R1 zero 0x008", 12'h008, 32'h0);
        expect_word("R1 zero 0x0D4", 12'h0D4, 32'h0);
        expect_word("R2 strap 0x004", 12'h004, 32'h1234_5678);
        expect_word("R2 variant 0x07C", 12'h07C, 32'h0000_0300);
    endtask

    // R3: read-only words ignore writes
    task automatic t_read_only();
        wr_word(12'h000, 32'hFFFF_FFFF);
        wr_word(12'h004, 32'h0);
        wr_word(12'h040, 32'hDEAD_BEEF);
        expect_word("R3 0x000", 12'h000, 32'h04A9_2750);
        expect_word("R3 0x004", 12'h004, 32'h1234_5678);
        expect_word("R3 0x040", 12'h040, 32'h0);
    endtask

    // R4: write-one-to-clear words
    task automatic t_w1c();
        wr_word(12'h06C, 32'h7FFF_FFFF);
        expect_word("R4 zeros keep", 12'h06C, 32'h8000_0000);
        wr_word(12'h06C, 32'h8000_0000);
        expect_word("R4 one clears", 12'h06C, 32'h0);
        wr_word(12'h0D4, 32'hFFFF_FFFF);
        expect_word("R4 0x0D4 stays zero", 12'h0D4, 32'h0);
    endtask

    // R5: write-one-to-set words
    task automatic t_w1s();
        wr_word(12'h070, 32'h0000_0005);
        expect_word("R5 set 0x070", 12'h070, 32'h0000_0005);
        wr_word(12'h070, 32'h0000_000A);
        expect_word("R5 accumulate", 12'h070, 32'h0000_000F);
        wr_word(12'h070, 32'h0);
        expect_word("R5 no clear", 12'h070, 32'h0000_000F);
        wr_word(12'h07C, 32'h0001_0001);
        expect_word("R5 0x07C or", 12'h07C, 32'h0001_0301);
    endtask

    // R6: plain storage, including gaps and the scratch word
    task automatic t_plain();
        wr_word(12'h13C, 32'hCAFE_0001);
        expect_word("R6 scratch", 12'h13C, 32'hCAFE_0001);
        wr_word(12'h008, 32'hA5A5_5A5A);
        expect_word("R6 gap 0x008", 12'h008, 32'hA5A5_5A5A);
        wr_word(12'h0D0, 32'h0F0F_F0F0);
        expect_word("R6 0x0D0", 12'h0D0, 32'h0F0F_F0F0);
        wr_word(12'h144, 32'h0);
        expect_word("R6 last word", 12'h144, 32'h0);
    endtask

    // R7: out-of-range accesses
    task automatic t_out_of_range();
        expect_word("R7 read 0x148", 12'h148, 32'h0);
        wr_word(12'h148, 32'hFFFF_FFFF);
        expect_word("R7 read after write 0x148", 12'h148, 32'h0);
        wr_word(12'hFFC, 32'h1357_9BDF);
        expect_word("R7 read 0xFFC", 12'hFFC, 32'h0);
        expect_word("R7 no alias 0x048", 12'h048, 32'h0);
        expect_word("R7 scratch intact", 12'h13C, 32'hCAFE_0001);
        expect_word("R7 last word intact", 12'h144, 32'h0);
    endtask

    // R8: one-cycle latency, read sees value before same-cycle write
    task automatic t_same_cycle();
        @(negedge clk);
        bus_addr = 10'h13C >> 2; bus_wdata = 32'h0BAD_F00D;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R8 old value on collision", bus_rdata, 32'hCAFE_0001);
        expect_word("R8 new value next read", 12'h13C, 32'h0BAD_F00D);
    endtask

    // R9: read data holds without a read strobe
    task automatic t_hold();
        expect_word("R9 setup", 12'h014, 32'h0000_FFFF);
        repeat (3) @(negedge clk);
        check("R9 idle hold", bus_rdata, 32'h0000_FFFF);
        wr_word(12'h014, 32'h1111_2222);
        check("R9 hold across write", bus_rdata, 32'h0000_FFFF);
    endtask

    // R2, R1: second reset with new strap and variant values
    task automatic t_second_reset();
        apply_reset(32'h8765_4321, 32'hF000_000F);
        check("R9 rdata after second reset", bus_rdata, 32'h0);
        expect_word("R2 new strap", 12'h004, 32'h8765_4321);
        expect_word("R2 new variant", 12'h07C, 32'hF000_000F);
        expect_word("R1 lock reset", 12'h070, 32'h0);
        expect_word("R1 scratch reset", 12'h13C, 32'h0000_0008);
        expect_word("R1 reset cause reset", 12'h06C, 32'h8000_0000);
    endtask

    initial begin
        apply_reset(32'h1234_5678, 32'h0000_0300);
        t_reset_values();
        t_read_only();
        t_w1c();
        t_w1s();
        t_plain();
        t_out_of_range();
        t_same_cycle();
        t_hold();
        t_second_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule